// File: doc/BRIEF.md
# Dual-Channel DAC Command Decoder

This block is the digital control core of a two-channel, 10-bit, serially programmed converter. A serial front end, outside this block, assembles a 16-bit command word and holds it on `cmd_word`. The word is acted on only when the active-low chip-select `cs_n` returns high. That rising edge is brought into the system clock domain through a synchroniser. The decoded command then updates a pair of input registers and a pair of output (DAC) registers, separately or together. It can also set per-channel shutdown flags, a general-purpose output pin and the edge-mode bit used by the serial output stage.

The top three bits of the word form a header. The header selects between loading an input register, loading and then transferring, loading everything directly, transferring stored values, and shutting both channels down. When the header is zero, the four most significant data bits become an extended opcode. That opcode gives per-channel wake and shutdown, control of the output pin and the edge mode.

Two asynchronous level inputs are also synchronised. An active-low clear zeroes all code registers. A lockout input, when low, blocks shutdown, and its falling edge wakes any channel that is shut down.

Top module: `dac_cmd_core`

## Requirements
- R1: After a synchronous reset, both codes are 0, both shutdown flags are 0, `aux_out` is 0, `dout_rise` is 0 and `cmd_done` is 0.
- R2: A command executes only on a rising edge of `cs_n`. `cmd_done` pulses high for one cycle on the third rising clock edge after `cs_n` rises. While `cs_n` stays low, changes of `cmd_word` have no effect. Word layout: bit 15 is A0, bits 14:13 are C1:C0, bits 12:3 are data D9..D0, and bits 2:0 are zero.
- R3: Header 001 loads input register A and header 101 loads input register B from the data field; the DAC codes do not change.
- R4: Header 010 (or 110) loads input A (or B), then copies both input registers to the DAC registers. The copy uses the value just loaded.
- R5: Header 011 loads both input registers and both DAC registers from the data field.
- R6: Header 100 copies both input registers into their DAC registers.
- R7: Header 111 sets both shutdown flags when `lockout_n` is high. While `lockout_n` is low, every shutdown command, including the extended ones, leaves the flags unchanged.
- R8: With header 000, bits 12:10 select an extended opcode. 001 copies input A to DAC A and 101 copies input B to DAC B. 110 shuts down channel A and 111 shuts down channel B.
- R9: Extended opcode 011 drives `aux_out` high and 010 drives it low.
- R10: Extended opcode 100 with bit 9 = 1 sets `dout_rise` to 1 (rising-edge output). With bit 9 = 0 it clears `dout_rise` to 0 (falling-edge output).
- R11: Extended opcode 000 is a no-operation: no output changes, whatever the other data bits are.
- R12: Any command that writes a channel's DAC register clears that channel's shutdown flag. Shutdown leaves the input register contents intact.
- R13: A high-to-low transition of `lockout_n` clears both shutdown flags three clock edges later, with no command, and leaves the codes unchanged.
- R14: While `clr_n` is low, the input and DAC registers of both channels are held at zero from the third clock edge on. A command whose `cs_n` rise is seen during the clear updates no register, although `cmd_done` still pulses. `aux_out`, `dout_rise` and the shutdown flags are not affected by the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Asynchronous chip-select, command executes on its rising edge |
| cmd_word | input | 16 | Assembled command word, held stable across the `cs_n` rise |
| clr_n | input | 1 | Asynchronous active-low clear of all code registers |
| lockout_n | input | 1 | Active-low shutdown lockout; its falling edge wakes both channels |
| code_a | output | 10 | DAC register of channel A |
| code_b | output | 10 | DAC register of channel B |
| shdn_a | output | 1 | Channel A shutdown flag |
| shdn_b | output | 1 | Channel B shutdown flag |
| aux_out | output | 1 | General-purpose output bit |
| dout_rise | output | 1 | Serial-output edge mode: 1 rising, 0 falling |
| cmd_done | output | 1 | One-cycle strobe for each accepted `cs_n` rise |

## Verification
Every result is due on the third rising clock edge after its asynchronous cause. That cause is the `cs_n` rise for commands, the `lockout_n` fall for wake-up, and the `clr_n` fall for clearing. Two synchroniser stages come first, then the register update. The driver releases `cs_n` at a falling edge. It confirms that `cmd_done` is still low two falling edges later and high on the third. At that same falling edge, the monitor pops the expected outputs and compares them. Clear and wake-up checks wait four falling edges after the level change, which places them safely past the third rising edge.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;

  // Header values formed by word bits A0, C1, C0
  typedef enum logic [2:0] {
    HDR_EXT      = 3'b000,
    HDR_LD_A     = 3'b001,
    HDR_LDXFER_A = 3'b010,
    HDR_LD_ALL   = 3'b011,
    HDR_XFER     = 3'b100,
    HDR_LD_B     = 3'b101,
    HDR_LDXFER_B = 3'b110,
    HDR_SD_ALL   = 3'b111
  } dac_hdr_e;

  // Extended opcodes in the top three data bits when the header is zero
  typedef enum logic [2:0] {
    EXT_NOP    = 3'b000,
    EXT_WAKE_A = 3'b001,
    EXT_AUX_LO = 3'b010,
    EXT_AUX_HI = 3'b011,
    EXT_EDGE   = 3'b100,
    EXT_WAKE_B = 3'b101,
    EXT_SD_A   = 3'b110,
    EXT_SD_B   = 3'b111
  } dac_ext_e;

  localparam int NUM_CH = 2;

  // Decoded actions; index 0 is channel A, index 1 channel B
  typedef struct packed {
    logic [NUM_CH-1:0] ld_in;
    logic [NUM_CH-1:0] xfer;
    logic [NUM_CH-1:0] sd;
    logic              aux_lo;
    logic              aux_hi;
    logic              edge_rise;
    logic              edge_fall;
  } dac_act_t;

endpackage

// File: rtl/dac_sync.sv
module dac_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= RST_VAL;
    else     stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= RST_VAL;
      else     stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/dac_cmd_decode.sv
module dac_cmd_decode
  import dac_cmd_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int WORD_W = 16
) (
  input  logic [WORD_W-1:0] word,
  output dac_act_t          act,
  output logic [DATA_W-1:0] data
);

  localparam int HDR_W   = 3;
  localparam int DATA_HI = WORD_W - HDR_W - 1;

  logic [HDR_W-1:0] hdr;
  logic [3:0]       ext;

  assign hdr  = word[WORD_W-1 -: HDR_W];
  assign data = word[DATA_HI -: DATA_W];
  assign ext  = word[DATA_HI -: 4];

  always_comb begin
    act = '0;
    case (dac_hdr_e'(hdr))
      HDR_LD_A:     act.ld_in[0] = 1'b1;
      HDR_LD_B:     act.ld_in[1] = 1'b1;
      HDR_LDXFER_A: begin act.ld_in[0] = 1'b1; act.xfer = '1; end
      HDR_LDXFER_B: begin act.ld_in[1] = 1'b1; act.xfer = '1; end
      HDR_LD_ALL:   begin act.ld_in = '1; act.xfer = '1; end
      HDR_XFER:     act.xfer = '1;
      HDR_SD_ALL:   act.sd = '1;
      HDR_EXT: begin
        case (dac_ext_e'(ext[3:1]))
          EXT_WAKE_A: act.xfer[0] = 1'b1;
          EXT_WAKE_B: act.xfer[1] = 1'b1;
          EXT_SD_A:   act.sd[0]   = 1'b1;
          EXT_SD_B:   act.sd[1]   = 1'b1;
          EXT_AUX_LO: act.aux_lo  = 1'b1;
          EXT_AUX_HI: act.aux_hi  = 1'b1;
          EXT_EDGE: begin
            act.edge_rise = ext[0];
            act.edge_fall = ~ext[0];
          end
          default: ;
        endcase
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/dac_chan.sv
module dac_chan #(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              ld_in,
  input  logic              xfer,
  input  logic              sd,
  input  logic              lk_ok,
  input  logic              wake,
  input  logic [DATA_W-1:0] data,
  output logic [DATA_W-1:0] code,
  output logic              shdn
);

  logic [DATA_W-1:0] in_r;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      in_r <= '0;
      code <= '0;
    end else begin
      if (ld_in) in_r <= data;
      if (xfer)  code <= ld_in ? data : in_r;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                shdn <= 1'b0;
    else if (wake || xfer)  shdn <= 1'b0;
    else if (sd && lk_ok)   shdn <= 1'b1;
  end

  // R7
  sd_lock_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(shdn) |-> $past(sd && lk_ok));

  // R12
  xfer_wake_chk: assert property (@(posedge clk) disable iff (rst)
    xfer |=> !shdn);

  // R14
  clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (code == '0));

endmodule

// File: rtl/dac_cmd_core.sv
module dac_cmd_core
  import dac_cmd_pkg::*;
#(
  parameter int DATA_W      = 10,
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic [WORD_W-1:0] cmd_word,
  input  logic              clr_n,
  input  logic              lockout_n,
  output logic [DATA_W-1:0] code_a,
  output logic [DATA_W-1:0] code_b,
  output logic              shdn_a,
  output logic              shdn_b,
  output logic              aux_out,
  output logic              dout_rise,
  output logic              cmd_done
);

  logic cs_s, clr_s, lk_s;
  logic cs_d, lk_d;
  logic cs_rise, clearing, exec, wake;

  dac_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({cs_n, clr_n, lockout_n}),
    .q   ({cs_s, clr_s, lk_s})
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_d <= 1'b1;
      lk_d <= 1'b1;
    end else begin
      cs_d <= cs_s;
      lk_d <= lk_s;
    end
  end

  assign cs_rise  = cs_s & ~cs_d;
  assign clearing = ~clr_s;
  assign exec     = cs_rise & ~clearing;
  assign wake     = lk_d & ~lk_s;

  dac_act_t          act;
  logic [DATA_W-1:0] data;

  dac_cmd_decode #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_dec (
    .word (cmd_word),
    .act  (act),
    .data (data)
  );

  logic [DATA_W-1:0] code_v [NUM_CH];
  logic [NUM_CH-1:0] shdn_v;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    dac_chan #(.DATA_W(DATA_W)) u_ch (
      .clk   (clk),
      .rst   (rst),
      .clr   (clearing),
      .ld_in (exec & act.ld_in[g]),
      .xfer  (exec & act.xfer[g]),
      .sd    (exec & act.sd[g]),
      .lk_ok (lk_s),
      .wake  (wake),
      .data  (data),
      .code  (code_v[g]),
      .shdn  (shdn_v[g])
    );
  end

  assign code_a = code_v[0];
  assign code_b = code_v[1];
  assign shdn_a = shdn_v[0];
  assign shdn_b = shdn_v[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      aux_out   <= 1'b0;
      dout_rise <= 1'b0;
      cmd_done  <= 1'b0;
    end else begin
      cmd_done <= cs_rise;
      if (exec) begin
        if (act.aux_hi)      aux_out <= 1'b1;
        else if (act.aux_lo) aux_out <= 1'b0;
        if (act.edge_rise)      dout_rise <= 1'b1;
        else if (act.edge_fall) dout_rise <= 1'b0;
      end
    end
  end

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_done |=> !cmd_done);

  // R9
  aux_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(aux_out) |-> cmd_done);

  // R10
  edge_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(dout_rise) |-> cmd_done);

  // R13
  wake_chk: assert property (@(posedge clk) disable iff (rst)
    wake |=> (!shdn_a && !shdn_b));

endmodule

// File: tb/test_dac_cmd_core.sv
module test_dac_cmd_core;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1;
  logic [15:0] cmd_word = '0;
  logic        clr_n = 1'b1;
  logic        lockout_n = 1'b1;
  logic [9:0]  code_a, code_b;
  logic        shdn_a, shdn_b, aux_out, dout_rise, cmd_done;

  always #4 clk = ~clk;

  dac_cmd_core i_dac_cmd_core (
    .clk(clk), .rst(rst), .cs_n(cs_n), .cmd_word(cmd_word),
    .clr_n(clr_n), .lockout_n(lockout_n),
    .code_a(code_a), .code_b(code_b), .shdn_a(shdn_a), .shdn_b(shdn_b),
    .aux_out(aux_out), .dout_rise(dout_rise), .cmd_done(cmd_done)
  );

  int compared = 0;
  int mismatched = 0;

  // Bench model, built from the requirements
  logic [9:0] m_in [2];
  logic [9:0] m_code [2];
  logic [1:0] m_sd;
  logic       m_aux, m_edge;
  logic       m_lk, m_clr;

  typedef struct {
    logic [23:0] v;
    string       tag;
  } exp_t;
  exp_t q[$];

  function automatic logic [23:0] model_vec();
    return {m_code[0], m_code[1], m_sd[0], m_sd[1], m_aux, m_edge};
  endfunction

  function automatic logic [23:0] obs_vec();
    return {code_a, code_b, shdn_a, shdn_b, aux_out, dout_rise};
  endfunction

  task automatic check(input logic ok, input string tag,
                       input logic [23:0] act, input logic [23:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer_ch(input int c);
    m_code[c] = m_in[c];
    m_sd[c] = 1'b0;
  endtask

  task automatic model_apply(input logic [15:0] w);
    logic [2:0] h;
    logic [9:0] d;
    h = w[15:13];
    d = w[12:3];
    if (m_clr) return;
    case (h)
      3'b001: m_in[0] = d;
      3'b101: m_in[1] = d;
      3'b010: begin m_in[0] = d; xfer_ch(0); xfer_ch(1); end
      3'b110: begin m_in[1] = d; xfer_ch(0); xfer_ch(1); end
      3'b011: begin m_in[0] = d; m_in[1] = d; xfer_ch(0); xfer_ch(1); end
      3'b100: begin xfer_ch(0); xfer_ch(1); end
      3'b111: if (m_lk) m_sd = 2'b11;
      default: begin
        case (d[9:7])
          3'b001: xfer_ch(0);
          3'b101: xfer_ch(1);
          3'b110: if (m_lk) m_sd[0] = 1'b1;
          3'b111: if (m_lk) m_sd[1] = 1'b1;
          3'b010: m_aux = 1'b0;
          3'b011: m_aux = 1'b1;
          3'b100: m_edge = d[6];
          default: ;
        endcase
      end
    endcase
  endtask

  // Driver: issues a command, pushes the expected outputs, checks strobe timing
  task automatic send(input logic [15:0] w, input string tag);
    exp_t e;
    @(negedge clk);
    cmd_word = w;
    cs_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    cs_n = 1'b1;
    model_apply(w);
    e.v = model_vec();
    e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    @(negedge clk);
    check(cmd_done == 1'b0, "R2 strobe early", {23'b0, cmd_done}, 24'h0);
    @(negedge clk);
    check(cmd_done == 1'b1, "R2 strobe due", {23'b0, cmd_done}, 24'h1);
    @(negedge clk);
  endtask

  function automatic logic [15:0] dword(input logic [2:0] h, input logic [9:0] d);
    return {h, d, 3'b000};
  endfunction

  function automatic logic [15:0] xword(input logic [3:0] op, input logic [5:0] rest);
    return {3'b000, op, rest, 3'b000};
  endfunction

  // Monitor: compares every executed command against the queue
  always @(negedge clk) begin
    if (!rst && cmd_done) begin
      if (q.size() == 0) begin
        check(1'b0, "R2 unexpected strobe", obs_vec(), 24'h0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(obs_vec() == e.v, e.tag, obs_vec(), e.v);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    m_in[0] = '0; m_in[1] = '0; m_code[0] = '0; m_code[1] = '0;
    m_sd = '0; m_aux = 0; m_edge = 0; m_lk = 1; m_clr = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check({obs_vec(), cmd_done} == 25'h0, "R1 reset", obs_vec(), 24'h0);

    send(dword(3'b001, 10'h155), "R3 load A only");
    send(dword(3'b101, 10'h2AA), "R3 load B only");
    send(dword(3'b100, 10'h000), "R6 copy both");
    send(dword(3'b010, 10'h3FF), "R4 load A then copy");
    send(dword(3'b110, 10'h001), "R4 load B then copy");
    send(dword(3'b011, 10'h200), "R5 load all");
    send(dword(3'b001, 10'h0AB), "R3 stage A");
    send(xword(4'b0010, 6'h15), "R8 ext copy A");
    send(dword(3'b101, 10'h123), "R3 stage B");
    send(xword(4'b1010, 6'h00), "R8 ext copy B");
    send(xword(4'b1100, 6'h00), "R8 shut A");
    send(xword(4'b1110, 6'h3F), "R8 shut B");
    send(dword(3'b001, 10'h050), "R12 load while shut");
    send(xword(4'b0010, 6'h00), "R12 wake A");
    send(xword(4'b1010, 6'h00), "R12 wake B keeps input");
    send(xword(4'b0110, 6'h00), "R9 aux high");
    send(xword(4'b0100, 6'h00), "R9 aux low");
    send(xword(4'b1001, 6'h00), "R10 edge rising");
    send(xword(4'b1000, 6'h00), "R10 edge falling");
    send(xword(4'b0001, 6'h2A), "R11 nop");
    send(xword(4'b0000, 6'h3F), "R11 nop other bits");
    send(dword(3'b111, 10'h3FF), "R7 shut both");

    // R13 lockout fall wakes both channels
    lockout_n = 1'b0;
    m_lk = 1'b0;
    m_sd = 2'b00;
    repeat (4) @(negedge clk);
    check(obs_vec() == model_vec(), "R13 lockout wake", obs_vec(), model_vec());
    send(dword(3'b111, 10'h000), "R7 shut blocked");
    send(xword(4'b1100, 6'h00), "R7 ext shut blocked");
    lockout_n = 1'b1;
    m_lk = 1'b1;
    repeat (4) @(negedge clk);

    // R2 word changes while chip-select low have no effect
    @(negedge clk);
    cs_n = 1'b0;
    for (int i = 0; i < 8; i++) begin
      cmd_word = dword(3'b011, 10'(i * 97));
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
    check(obs_vec() == model_vec(), "R2 no exec while low", obs_vec(), model_vec());
    cmd_word = xword(4'b0000, 6'h00);
    @(negedge clk);
    cs_n = 1'b1;
    begin
      exp_t e;
      model_apply(cmd_word);
      e.v = model_vec();
      e.tag = "R2 nop after hold";
      q.push_back(e);
    end
    repeat (5) @(negedge clk);

    // R14 clear
    send(xword(4'b0110, 6'h00), "R14 aux set before clear");
    clr_n = 1'b0;
    m_clr = 1'b1;
    m_in[0] = '0; m_in[1] = '0; m_code[0] = '0; m_code[1] = '0;
    repeat (4) @(negedge clk);
    check(obs_vec() == model_vec(), "R14 clear zeroes codes", obs_vec(), model_vec());
    send(dword(3'b011, 10'h3FF), "R14 command during clear");
    clr_n = 1'b1;
    m_clr = 1'b0;
    repeat (4) @(negedge clk);
    send(dword(3'b100, 10'h000), "R14 inputs cleared");

    repeat (4) @(negedge clk);
    check(q.size() == 0, "R2 all commands executed", 24'(q.size()), 24'h0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule